// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator and Vector Selector

This block gathers interrupt requests from four peripheral sources: a keyboard line combined with an external interrupt pin, a low-voltage detector, a serial peripheral interface unit and an asynchronous serial unit. It gates each source's flags with their enables and applies the CPU's global interrupt mask bit. It then drives one registered interrupt request to the CPU. Next to that request it drives the 16-bit address of the vector pair that belongs to the highest-priority pending source.

The block holds no flag state. Every flag is an input, and the peripheral that owns it clears it. The asynchronous serial unit supplies its whole status byte. Only the five upper bits of that byte are interrupt flags, and each has its own enable. While the CPU fetches the vector, it raises an acknowledge strobe, and the selected address stays frozen for as long as that strobe is high.

Top module: `irq_vector_agg`

## Requirements
- R1: During and after reset, `cpuIrq` is 0 and `vecAddr` is 16'hFFF0 until the first request passes the mask.
- R2: The keyboard/IRQ source is pending when `extIrq` is 1 or when both `kbdFlag` and `kbdEn` are 1. Its vector address is 16'hFFFA.
- R3: The low-voltage source is pending when `lvFlag` and `lvEn` are both 1. Its vector address is 16'hFFF4.
- R4: The SPI source is pending when `spiEn` is 1 and any bit of `spiFlags` is 1. Its vector address is 16'hFFF2.
- R5: The serial-comms source is pending when `sciStatus[7-k]` and `sciEn[4-k]` are both 1 for some k in 0..4, so that `sciEn[4]` pairs with status bit 7 and `sciEn[0]` pairs with bit 3. Status bits 2..0 are ignored. Its vector address is 16'hFFF0.
- R6: When several sources are pending at once, fixed priority applies. From highest to lowest the order is keyboard/IRQ, low voltage, SPI, serial comms.
- R7: When `iMask` is 1 at a clock edge, `cpuIrq` is 0 after that edge, whatever the sources are doing.
- R8: `cpuIrq` and `vecAddr` are registered. After each edge, `cpuIrq` is 1 exactly when some source was pending and `iMask` was 0 at that edge.
- R9: `vecAddr` loads the winner's vector only at an edge where a request passes the mask and `ackStrobe` is 0. Otherwise it keeps its value, which means it holds while `ackStrobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| iMask | input | 1 | Global interrupt mask bit from the CPU status |
| kbdFlag | input | 1 | Keyboard interrupt flag |
| kbdEn | input | 1 | Keyboard interrupt enable |
| extIrq | input | 1 | External interrupt request sharing the keyboard vector |
| lvFlag | input | 1 | Low-voltage flag |
| lvEn | input | 1 | Low-voltage interrupt enable |
| spiFlags | input | 2 | SPI status interrupt flags |
| spiEn | input | 1 | SPI interrupt enable |
| sciStatus | input | 8 | Serial-comms status byte; bits 7..3 are flags |
| sciEn | input | 5 | Per-flag enables for status bits 7..3 |
| ackStrobe | input | 1 | CPU vector fetch acknowledge |
| cpuIrq | output | 1 | Registered interrupt request to the CPU |
| vecAddr | output | 16 | Registered address of the winning vector pair |

## Verification
Some properties are checked on every cycle. The grant vector is at most one-hot, and the keyboard/IRQ source always wins when it is pending. A high mask forces the request low on the next cycle, and any request that passes the mask raises it. The vector address is always one of the four legal values, and it is unchanged in the cycle after an acknowledge. Other behaviour can only be shown by the bench's scenarios: the exact mapping from each flag and enable combination to its vector, the pairing of serial enables to status bits, the fact that the low status bits are ignored, and the full priority order among the three lower sources.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int NUM_SRC = 4;
  // Priority index: lower index wins
  localparam int SRC_KBD = 0;
  localparam int SRC_LV  = 1;
  localparam int SRC_SPI = 2;
  localparam int SRC_SCI = 3;

  typedef struct packed {
    logic loadVec;  // capture winner vector this edge
    logic raise;    // request to present to CPU next cycle
  } ctlStrobe_t;
endpackage

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SPI_FLAG_W = 2,
  parameter int SCI_STAT_W = 8,
  parameter int SCI_FLAG_N = 5,
  parameter logic [ADDR_W-1:0] VEC_KBD = 16'hFFFA,
  parameter logic [ADDR_W-1:0] VEC_LV  = 16'hFFF4,
  parameter logic [ADDR_W-1:0] VEC_SPI = 16'hFFF2,
  parameter logic [ADDR_W-1:0] VEC_SCI = 16'hFFF0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  kbdFlag,
  input  logic                  kbdEn,
  input  logic                  extIrq,
  input  logic                  lvFlag,
  input  logic                  lvEn,
  input  logic [SPI_FLAG_W-1:0] spiFlags,
  input  logic                  spiEn,
  input  logic [SCI_STAT_W-1:0] sciStatus,
  input  logic [SCI_FLAG_N-1:0] sciEn,
  input  ctlStrobe_t            strobes,
  output logic [NUM_SRC-1:0]    reqVec,
  output logic [ADDR_W-1:0]     vecAddr
);
  localparam int SCI_LSB = SCI_STAT_W - SCI_FLAG_N;
  localparam logic [ADDR_W-1:0] VEC_TAB [NUM_SRC] = '{VEC_KBD, VEC_LV, VEC_SPI, VEC_SCI};

  logic [SCI_FLAG_N-1:0] sciHits;
  logic [NUM_SRC-1:0]    grant;
  logic [ADDR_W-1:0]     winVec;
  logic                  unusedLowBits;

  assign sciHits       = sciStatus[SCI_STAT_W-1:SCI_LSB] & sciEn;
  assign unusedLowBits = ^sciStatus[SCI_LSB-1:0];

  // Per-source pending terms
  always_comb begin
    reqVec          = '0;
    reqVec[SRC_KBD] = extIrq | (kbdFlag & kbdEn);
    reqVec[SRC_LV]  = lvFlag & lvEn;
    reqVec[SRC_SPI] = spiEn & (|spiFlags);
    reqVec[SRC_SCI] = |sciHits;
  end

  // Fixed-priority grant, index 0 highest
  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_grant
      if (gi == 0) begin : g_top
        assign grant[gi] = reqVec[gi];
      end else begin : g_rest
        assign grant[gi] = reqVec[gi] & ~(|reqVec[gi-1:0]);
      end
    end
  endgenerate

  always_comb begin
    winVec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      winVec = winVec | ({ADDR_W{grant[i]}} & VEC_TAB[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) vecAddr <= VEC_SCI;
    else if (strobes.loadVec) vecAddr <= winVec;
  end

  p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));
  p_top_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    reqVec[SRC_KBD] |-> (grant == 4'b0001));
  p_vec_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    (vecAddr == VEC_KBD) || (vecAddr == VEC_LV) || (vecAddr == VEC_SPI) || (vecAddr == VEC_SCI));
endmodule

// File: rtl/irq_agg_control.sv
module irq_agg_control
  import irq_agg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqVec,
  input  logic               iMask,
  input  logic               ackStrobe,
  output ctlStrobe_t         strobes,
  output logic               cpuIrq
);
  logic anyReq;
  assign anyReq = |reqVec;

  always_comb begin
    strobes.raise   = anyReq & ~iMask;
    strobes.loadVec = anyReq & ~iMask & ~ackStrobe;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cpuIrq <= 1'b0;
    else       cpuIrq <= strobes.raise;
  end

  p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    iMask |=> !cpuIrq);
  p_irq_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    (anyReq && !iMask) |=> cpuIrq);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !anyReq |=> !cpuIrq);
endmodule

// File: rtl/irq_vector_agg.sv
module irq_vector_agg
  import irq_agg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        iMask,
  input  logic        kbdFlag,
  input  logic        kbdEn,
  input  logic        extIrq,
  input  logic        lvFlag,
  input  logic        lvEn,
  input  logic [1:0]  spiFlags,
  input  logic        spiEn,
  input  logic [7:0]  sciStatus,
  input  logic [4:0]  sciEn,
  input  logic        ackStrobe,
  output logic        cpuIrq,
  output logic [15:0] vecAddr
);
  ctlStrobe_t         strobes;
  logic [NUM_SRC-1:0] reqVec;

  irq_agg_datapath #(
    .ADDR_W(16), .SPI_FLAG_W(2), .SCI_STAT_W(8), .SCI_FLAG_N(5)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .kbdFlag(kbdFlag), .kbdEn(kbdEn), .extIrq(extIrq),
    .lvFlag(lvFlag), .lvEn(lvEn),
    .spiFlags(spiFlags), .spiEn(spiEn),
    .sciStatus(sciStatus), .sciEn(sciEn),
    .strobes(strobes), .reqVec(reqVec), .vecAddr(vecAddr)
  );

  irq_agg_control u_ctl (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .iMask(iMask),
    .ackStrobe(ackStrobe), .strobes(strobes), .cpuIrq(cpuIrq)
  );

  p_hold_on_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    ackStrobe |=> $stable(vecAddr));
endmodule

// File: tb/sim_irq_vector_agg.sv
`timescale 1ns/1ps
module sim_irq_vector_agg;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic iMask = 0, kbdFlag = 0, kbdEn = 0, extIrq = 0, lvFlag = 0, lvEn = 0, spiEn = 0, ackStrobe = 0;
  logic [1:0]  spiFlags = '0;
  logic [7:0]  sciStatus = '0;
  logic [4:0]  sciEn = '0;
  logic        cpuIrq;
  logic [15:0] vecAddr;

  int checks = 0;
  int failures = 0;
  logic        expIrq = 1'b0;
  logic [15:0] expVec = 16'hFFF0;
  bit          done = 0;

  always #2 clk = ~clk;

  irq_vector_agg u0 (
    .clk(clk), .rstN(rstN), .iMask(iMask), .kbdFlag(kbdFlag), .kbdEn(kbdEn),
    .extIrq(extIrq), .lvFlag(lvFlag), .lvEn(lvEn), .spiFlags(spiFlags),
    .spiEn(spiEn), .sciStatus(sciStatus), .sciEn(sciEn), .ackStrobe(ackStrobe),
    .cpuIrq(cpuIrq), .vecAddr(vecAddr)
  );

  // Returns pending bits {sci, spi, lv, kbd}
  function automatic logic [3:0] pendBits();
    logic [3:0] p;
    p[0] = extIrq | (kbdFlag & kbdEn);
    p[1] = lvFlag & lvEn;
    p[2] = spiEn & (|spiFlags);
    p[3] = |(sciStatus[7:3] & sciEn);
    return p;
  endfunction

  function automatic logic [15:0] winnerVec(logic [3:0] p);
    if (p[0]) return 16'hFFFA;
    if (p[1]) return 16'hFFF4;
    if (p[2]) return 16'hFFF2;
    return 16'hFFF0;
  endfunction

  function automatic string winnerTag(logic [3:0] p);
    if ($countones(p) > 1) return "R6";
    if (p[0]) return "R2";
    if (p[1]) return "R3";
    if (p[2]) return "R4";
    return "R5";
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clearIns();
    iMask = 0; kbdFlag = 0; kbdEn = 0; extIrq = 0; lvFlag = 0; lvEn = 0;
    spiFlags = '0; spiEn = 0; sciStatus = '0; sciEn = '0; ackStrobe = 0;
  endtask

  // One clock: inputs held across the edge, model advanced, outputs checked after it
  task automatic step();
    logic [3:0] p;
    string vtag;
    @(posedge clk);
    #1;
    p = pendBits();
    expIrq = (|p) & ~iMask;
    vtag = ackStrobe ? "R9" : winnerTag(p);
    if ((|p) && !iMask && !ackStrobe) expVec = winnerVec(p);
    else if (!(|p)) vtag = "R9";
    check(iMask ? "R7" : "R8", {15'b0, cpuIrq}, {15'b0, expIrq});
    check(vtag, vecAddr, expVec);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", {15'b0, cpuIrq}, 16'h0000);
    check("R1", vecAddr, 16'hFFF0);
    rstN = 1'b1;
    step();

    // R2: each keyboard/IRQ path on its own
    clearIns(); extIrq = 1; step();
    clearIns(); kbdFlag = 1; kbdEn = 1; step();
    clearIns(); kbdFlag = 1; step();             // flag without enable
    // R3 / R4
    clearIns(); lvFlag = 1; lvEn = 1; step();
    clearIns(); spiFlags = 2'b10; spiEn = 1; step();
    clearIns(); spiFlags = 2'b01; step();        // no enable
    // R5: each flag bit with its own enable only
    for (int k = 0; k < 5; k++) begin
      clearIns(); lvFlag = 1; lvEn = 1; step();  // move vector away from FFF0
      clearIns(); sciStatus = 8'h80 >> k; sciEn = 5'h10 >> k; step();
      check("R5", vecAddr, 16'hFFF0);
    end
    clearIns(); lvFlag = 1; lvEn = 1; step();
    clearIns(); sciStatus = 8'h80; sciEn = 5'h0F; step();   // mismatched enable
    clearIns(); sciStatus = 8'h07; sciEn = 5'h1F; step();   // R5 low bits ignored
    check("R5", {15'b0, cpuIrq}, 16'h0000);
    // R6: priority ladder
    clearIns(); extIrq = 1; lvFlag = 1; lvEn = 1; spiFlags = 2'b11; spiEn = 1;
    sciStatus = 8'hF8; sciEn = 5'h1F; step();
    check("R6", vecAddr, 16'hFFFA);
    extIrq = 0; step();
    check("R6", vecAddr, 16'hFFF4);
    lvEn = 0; step();
    check("R6", vecAddr, 16'hFFF2);
    // R7: mask with everything pending
    clearIns(); iMask = 1; extIrq = 1; lvFlag = 1; lvEn = 1; step();
    check("R7", {15'b0, cpuIrq}, 16'h0000);
    // R9: acknowledge freezes vector while a higher source appears
    clearIns(); sciStatus = 8'h08; sciEn = 5'h01; step();
    ackStrobe = 1; extIrq = 1; step(); step();
    check("R9", vecAddr, 16'hFFF0);
    ackStrobe = 0; step();
    check("R9", vecAddr, 16'hFFFA);

    // Constrained random
    for (int n = 0; n < 3000; n++) begin
      iMask     = ($urandom_range(0, 3) == 0);
      ackStrobe = ($urandom_range(0, 3) == 0);
      extIrq    = ($urandom_range(0, 7) == 0);
      kbdFlag   = $urandom_range(0, 1); kbdEn = ($urandom_range(0, 3) == 0);
      lvFlag    = $urandom_range(0, 1); lvEn  = ($urandom_range(0, 2) == 0);
      spiFlags  = 2'($urandom); spiEn = $urandom_range(0, 1);
      sciStatus = 8'($urandom); sciEn = 5'($urandom);
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule